// File: doc/BRIEF.md
# Masked Time-of-Day Alarm and Interrupt Selector

This block watches the running seconds, minutes, hours and day-of-month of a clock/calendar and raises an alarm when they agree with four programmable alarm fields. Each alarm field stores a BCD value together with a mask bit in its top bit. Taken together, the four mask bits select how often the alarm repeats: every second, or when one, two, three or all four of the time fields agree. On a match the block sets a sticky alarm flag. When enabled, it also pulls an active-low interrupt level low. Software releases the interrupt by reading or writing the flag register. The flag itself drops only after that access has finished.

The same interrupt line also carries a 512 Hz test tone and a watchdog request, and the block decides which source drives the line. Enabling the interrupt while on backup power needs a second enable. A power-up event clears both enables. An alarm that lands during that power-up event still sets the flag. The time counters, the tone divider, the watchdog and the open-drain pad sit outside the block, which receives their results as inputs.

Top module: `tod_alarm_irq`

## Requirements
- R1: The register select `bus_sel` picks 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm date (each 8 bits, read back as written, mask bit in bit 7). Select 4 is the enable register, with the alarm enable in bit 0 and the backup enable in bit 1; its other bits read 0. Select 5 is the flag register, with the alarm flag in bit 0 and all other bits reading 0; a write to it never sets the flag. Reset clears every register.
- R2: Using mask bits {date, hours, minutes, seconds}, code 1111 fires on every tick. Code 1110 needs seconds to agree. Code 1100 needs minutes and seconds to agree. Code 1000 needs hours, minutes and seconds to agree. Code 0000 needs all four fields to agree.
- R3: Any other mask code fires on every tick. Seconds and minutes are compared on bits 6:0, hours and date on bits 5:0, and the remaining bits of the time inputs are ignored.
- R4: Comparison happens only in a cycle where `tick` is 1, and the flag is visible in the cycle after that tick. The flag is set whatever the enables are. On main power, `irq_n` is 0 while the flag is set and the alarm enable is 1.
- R5: A read or write of the flag register releases `irq_n` from the cycle after the access starts. The flag still reads 1 for the whole access and clears in the cycle after the access ends.
- R6: While `on_backup` is 1, the alarm drives `irq_n` low only if both the alarm enable and the backup enable are 1.
- R7: `pwr_up` clears both enables, and takes priority over a write in the same cycle. A match in that same cycle still sets the flag.
- R8: When no alarm or watchdog request is active, `irq_n` follows `tone512` if all four of these hold: `osc_run` is 1, `ft_en` is 1, the alarm enable is 0, and either `wd_steer` is 1 or `wd_cfg` is 00h. Otherwise `irq_n` is 1.
- R9: `wd_irq` drives `irq_n` low and prevails over the test tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second strobe; time inputs are already updated |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours, BCD |
| t_date | input | 8 | Current day of month, BCD |
| on_backup | input | 1 | 1 while running from backup power |
| pwr_up | input | 1 | Power-up event pulse |
| bus_rd | input | 1 | Register read strobe, held for the access |
| bus_wr | input | 1 | Register write strobe, held for the access |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| osc_run | input | 1 | Oscillator running |
| ft_en | input | 1 | Frequency-test request bit |
| wd_steer | input | 1 | Watchdog steering bit |
| wd_cfg | input | 8 | Watchdog register value |
| wd_irq | input | 1 | Watchdog interrupt request |
| tone512 | input | 1 | 512 Hz square wave |
| irq_n | output | 1 | Active-low interrupt level |
| alarm_flag | output | 1 | Alarm flag |

## Verification
The bench sweeps all sixteen mask codes against all sixteen patterns of which fields agree. Because of this, a decoder that gives an illegal code the wrong rate, or swaps the field order, shows up as a flag raised or missed at exactly that code. Ignored high bits are set to 1 in the time inputs on agreeing fields, so a compare that includes them misses alarms. The flag-clear protocol is checked cycle by cycle. A design that drops the flag at the start of the access, or never releases the line, shows the wrong flag or interrupt mid-access. The bench also covers a power-up that coincides with a match, backup gating, and each term of the tone selection, so that a wrong precedence between watchdog, alarm and tone shows as a wrong interrupt level.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int FIELD_W   = 8;
    localparam int N_FIELDS  = 4;
    localparam int SEL_W     = 3;
    localparam int MASK_BIT  = FIELD_W - 1;
    localparam int N_WIDE    = 2;   // fields compared on FIELD_W-1 bits
    localparam int CFG_AE_BIT  = 0;
    localparam int CFG_ABE_BIT = 1;
    localparam int FLAG_AF_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_A_SEC   = 3'd0,
        SEL_A_MIN   = 3'd1,
        SEL_A_HOUR  = 3'd2,
        SEL_A_DATE  = 3'd3,
        SEL_ENABLES = 3'd4,
        SEL_FLAGS   = 3'd5
    } reg_sel_e;

    typedef enum logic [2:0] {
        RATE_EACH_SEC,
        RATE_SEC,
        RATE_MIN_SEC,
        RATE_HMS,
        RATE_FULL
    } rate_e;

    typedef struct packed {
        logic abe;
        logic ae;
    } irq_cfg_t;

    typedef logic [N_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    // Bits of a field that take part in the compare.
    function automatic logic [FIELD_W-1:0] value_mask(input int idx);
        logic [FIELD_W-1:0] m;
        m = '1;
        m[MASK_BIT] = 1'b0;
        if (idx >= N_WIDE) m[MASK_BIT-1] = 1'b0;
        return m;
    endfunction

    // Mask code ordering: {date, hours, minutes, seconds}.
    function automatic rate_e decode_rate(input logic [N_FIELDS-1:0] code);
        rate_e r;
        case (code)
            4'b1111: r = RATE_EACH_SEC;
            4'b1110: r = RATE_SEC;
            4'b1100: r = RATE_MIN_SEC;
            4'b1000: r = RATE_HMS;
            4'b0000: r = RATE_FULL;
            default: r = RATE_EACH_SEC;
        endcase
        return r;
    endfunction

    function automatic logic [N_FIELDS-1:0] fields_needed(input rate_e r);
        logic [N_FIELDS-1:0] n;
        case (r)
            RATE_SEC:     n = 4'b0001;
            RATE_MIN_SEC: n = 4'b0011;
            RATE_HMS:     n = 4'b0111;
            RATE_FULL:    n = 4'b1111;
            default:      n = 4'b0000;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_up,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [FIELD_W-1:0]   wdata,
    output field_vec_t           alarm_q,
    output irq_cfg_t             cfg_q
);
    logic [N_FIELDS-1:0] wr_hit;

    always_comb begin
        for (int i = 0; i < N_FIELDS; i++) begin
            wr_hit[i] = wr_en && (sel == reg_sel_e'(SEL_W'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
        end else begin
            for (int i = 0; i < N_FIELDS; i++) begin
                if (wr_hit[i]) alarm_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_up) begin
            cfg_q <= '0;
        end else if (wr_en && sel == SEL_ENABLES) begin
            cfg_q.ae  <= wdata[CFG_AE_BIT];
            cfg_q.abe <= wdata[CFG_ABE_BIT];
        end
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  logic        tick,
    input  field_vec_t  alarm_q,
    input  field_vec_t  time_now,
    output logic        fire
);
    logic [N_FIELDS-1:0] agree;
    logic [N_FIELDS-1:0] mcode;
    logic [N_FIELDS-1:0] need;
    rate_e               rate;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
        assign agree[i] = ((alarm_q[i] ^ time_now[i]) & value_mask(i)) == '0;
        assign mcode[i] = alarm_q[i][MASK_BIT];
    end

    assign rate = decode_rate(mcode);
    assign need = fields_needed(rate);
    assign fire = tick && ((agree | ~need) == '1);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                flag_acc,
    input  irq_cfg_t            cfg,
    input  logic                on_backup,
    input  logic                osc_run,
    input  logic                ft_en,
    input  logic                wd_steer,
    input  logic [FIELD_W-1:0]  wd_cfg,
    input  logic                wd_irq,
    input  logic                tone512,
    output logic                af,
    output logic                irq_n
);
    logic acc_q;
    logic rel_q;
    logic gate;
    logic alarm_req;
    logic ft_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            af    <= 1'b0;
            acc_q <= 1'b0;
            rel_q <= 1'b0;
        end else begin
            acc_q <= flag_acc;
            if (fire)                    af <= 1'b1;
            else if (acc_q && !flag_acc) af <= 1'b0;
            if (fire)          rel_q <= 1'b0;
            else if (flag_acc) rel_q <= 1'b1;
            else if (!af)      rel_q <= 1'b0;
        end
    end

    assign gate      = cfg.ae && (!on_backup || cfg.abe);
    assign alarm_req = af && !rel_q && gate;
    assign ft_sel    = osc_run && ft_en && !cfg.ae && (wd_steer || wd_cfg == '0);

    always_comb begin
        if (alarm_req || wd_irq) irq_n = 1'b0;
        else if (ft_sel)         irq_n = tone512;
        else                     irq_n = 1'b1;
    end
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [FIELD_W-1:0]  t_sec,
    input  logic [FIELD_W-1:0]  t_min,
    input  logic [FIELD_W-1:0]  t_hour,
    input  logic [FIELD_W-1:0]  t_date,
    input  logic                on_backup,
    input  logic                pwr_up,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [FIELD_W-1:0]  bus_wdata,
    output logic [FIELD_W-1:0]  bus_rdata,
    input  logic                osc_run,
    input  logic                ft_en,
    input  logic                wd_steer,
    input  logic [FIELD_W-1:0]  wd_cfg,
    input  logic                wd_irq,
    input  logic                tone512,
    output logic                irq_n,
    output logic                alarm_flag
);
    reg_sel_e   sel_e;
    field_vec_t alarm_q;
    field_vec_t time_now;
    irq_cfg_t   cfg;
    logic       fire;
    logic       flag_acc;

    assign sel_e    = reg_sel_e'(bus_sel);
    assign time_now = {t_date, t_hour, t_min, t_sec};
    assign flag_acc = (bus_rd || bus_wr) && sel_e == SEL_FLAGS;

    alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .pwr_up  (pwr_up),
        .wr_en   (bus_wr),
        .sel     (sel_e),
        .wdata   (bus_wdata),
        .alarm_q (alarm_q),
        .cfg_q   (cfg)
    );

    alarm_match u_match (
        .tick     (tick),
        .alarm_q  (alarm_q),
        .time_now (time_now),
        .fire     (fire)
    );

    irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .flag_acc  (flag_acc),
        .cfg       (cfg),
        .on_backup (on_backup),
        .osc_run   (osc_run),
        .ft_en     (ft_en),
        .wd_steer  (wd_steer),
        .wd_cfg    (wd_cfg),
        .wd_irq    (wd_irq),
        .tone512   (tone512),
        .af        (alarm_flag),
        .irq_n     (irq_n)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel_e)
            SEL_A_SEC:   bus_rdata = alarm_q[0];
            SEL_A_MIN:   bus_rdata = alarm_q[1];
            SEL_A_HOUR:  bus_rdata = alarm_q[2];
            SEL_A_DATE:  bus_rdata = alarm_q[3];
            SEL_ENABLES: begin
                bus_rdata[CFG_AE_BIT]  = cfg.ae;
                bus_rdata[CFG_ABE_BIT] = cfg.abe;
            end
            SEL_FLAGS:   bus_rdata[FLAG_AF_BIT] = alarm_flag;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk
    import alarm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [SEL_W-1:0]   bus_sel,
    input logic               af,
    input logic               irq_n,
    input logic               on_backup,
    input logic               pwr_up,
    input logic               ae,
    input logic               abe,
    input logic               wd_irq,
    input logic               ft_en
);
    logic flag_acc;
    assign flag_acc = (bus_rd || bus_wr) && bus_sel == SEL_FLAGS;

    a_r4_flag_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(tick));

    a_r5_flag_drops_after_access: assert property (@(posedge clk) disable iff (rst)
        $fell(af) |-> (!$past(flag_acc) && $past(flag_acc, 2)));

    a_r5_line_released: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_acc) && !$past(tick) && !wd_irq && !ft_en) |-> irq_n);

    a_r6_backup_needs_abe: assert property (@(posedge clk) disable iff (rst)
        (on_backup && !abe && !wd_irq && !ft_en) |-> irq_n);

    a_r7_powerup_clears: assert property (@(posedge clk) disable iff (rst)
        pwr_up |=> (!ae && !abe));

    a_r9_watchdog_wins: assert property (@(posedge clk) disable iff (rst)
        wd_irq |-> !irq_n);
endmodule

bind tod_alarm_irq alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .af        (alarm_flag),
    .irq_n     (irq_n),
    .on_backup (on_backup),
    .pwr_up    (pwr_up),
    .ae        (cfg.ae),
    .abe       (cfg.abe),
    .wd_irq    (wd_irq),
    .ft_en     (ft_en)
);

// File: tb/sim_tod_alarm_irq.sv
module sim_tod_alarm_irq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_date = '0;
    logic on_backup = 1'b0, pwr_up = 1'b0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic osc_run = 1'b0, ft_en = 1'b0, wd_steer = 1'b0;
    logic [7:0] wd_cfg = 8'h11;
    logic wd_irq = 1'b0, tone512 = 1'b0;
    logic irq_n, alarm_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tod_alarm_irq u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
        .on_backup(on_backup), .pwr_up(pwr_up),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_run(osc_run), .ft_en(ft_en), .wd_steer(wd_steer), .wd_cfg(wd_cfg),
        .wd_irq(wd_irq), .tone512(tone512),
        .irq_n(irq_n), .alarm_flag(alarm_flag)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        bus_sel = sel; bus_wdata = data; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] sel, input logic [7:0] exp);
        bus_sel = sel;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick_at(input logic [7:0] s, m, h, d);
        t_sec = s; t_min = m; t_hour = h; t_date = d; tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic flag_clear();
        bus_sel = 3'd5; bus_rd = 1'b1;
        cyc();
        bus_rd = 1'b0;
        cyc();
    endtask

    function automatic logic [3:0] need_of(input logic [3:0] c);
        case (c)
            4'hF: return 4'h0;
            4'hE: return 4'h1;
            4'hC: return 4'h3;
            4'h8: return 4'h7;
            4'h0: return 4'hF;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [7:0] base_of(input int i);
        case (i)
            0: return 8'h45;
            1: return 8'h37;
            2: return 8'h21;
            default: return 8'h19;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] tv [4];
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        check("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 reset flag", {7'd0, alarm_flag}, 8'h00);
        for (int s = 0; s < 6; s++) rd_check("R1 reset reg", 3'(s), 8'h00);

        // R1 readback
        wr(3'd0, 8'hC5); wr(3'd1, 8'h5A); wr(3'd2, 8'hA3); wr(3'd3, 8'h3C);
        wr(3'd4, 8'hFE);
        rd_check("R1 asec", 3'd0, 8'hC5);
        rd_check("R1 amin", 3'd1, 8'h5A);
        rd_check("R1 ahour", 3'd2, 8'hA3);
        rd_check("R1 adate", 3'd3, 8'h3C);
        rd_check("R1 enables", 3'd4, 8'h02);

        // R2 R3 R4 sweep: all mask codes x agreement patterns, AE=1 main power
        wr(3'd4, 8'h01);
        for (int code = 0; code < 16; code++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic [3:0] c4, p4, nd;
                logic exp;
                c4 = 4'(code); p4 = 4'(pat);
                for (int i = 0; i < 4; i++) begin
                    wr(3'(i), {c4[i], base_of(i)[6:0]});
                    if (p4[i]) tv[i] = base_of(i) | ((i < 2) ? 8'h80 : 8'hC0);
                    else       tv[i] = base_of(i) ^ 8'h01;
                end
                nd = need_of(c4);
                exp = ((p4 | ~nd) == 4'hF);
                tick_at(tv[0], tv[1], tv[2], tv[3]);
                check((c4 == 4'hF || c4 == 4'hE || c4 == 4'hC || c4 == 4'h8 || c4 == 4'h0)
                      ? "R2 rate flag" : "R3 illegal code flag",
                      {7'd0, alarm_flag}, {7'd0, exp});
                check("R4 irq level", {7'd0, irq_n}, {7'd0, ~exp});
                flag_clear();
            end
        end

        // every-second alarm for the remaining cases
        for (int i = 0; i < 4; i++) wr(3'(i), 8'h80);

        // R4 no compare without tick
        t_sec = 8'h00; cyc(); cyc();
        check("R4 no tick", {7'd0, alarm_flag}, 8'h00);

        // R4 flag sets with AE=0, line stays high
        wr(3'd4, 8'h00);
        tick_at(8'h01, 8'h02, 8'h03, 8'h04);
        check("R4 flag without enable", {7'd0, alarm_flag}, 8'h01);
        check("R4 line quiet without enable", {7'd0, irq_n}, 8'h01);
        wr(3'd4, 8'h01);
        check("R4 line after enable", {7'd0, irq_n}, 8'h00);

        // R5 read access protocol
        bus_sel = 3'd5; bus_rd = 1'b1;
        #1;
        check("R5 flag reads 1", bus_rdata, 8'h01);
        cyc();
        check("R5 released", {7'd0, irq_n}, 8'h01);
        check("R5 flag held", {7'd0, alarm_flag}, 8'h01);
        cyc();
        check("R5 flag held long", bus_rdata, 8'h01);
        bus_rd = 1'b0;
        cyc();
        check("R5 flag cleared", {7'd0, alarm_flag}, 8'h00);
        check("R5 line idle", {7'd0, irq_n}, 8'h01);

        // R5 write access, R1 write never sets flag
        tick_at(8'h09, 8'h09, 8'h09, 8'h09);
        check("R5 re-armed", {7'd0, irq_n}, 8'h00);
        bus_sel = 3'd5; bus_wdata = 8'h00; bus_wr = 1'b1;
        cyc();
        check("R5 write releases", {7'd0, irq_n}, 8'h01);
        check("R5 write flag held", {7'd0, alarm_flag}, 8'h01);
        bus_wr = 1'b0;
        cyc();
        check("R5 write clears", {7'd0, alarm_flag}, 8'h00);
        wr(3'd5, 8'hFF); cyc();
        check("R1 flag write ignored", {7'd0, alarm_flag}, 8'h00);

        // R6 backup gating
        on_backup = 1'b1;
        tick_at(8'h10, 8'h10, 8'h10, 8'h10);
        check("R6 backup flag", {7'd0, alarm_flag}, 8'h01);
        check("R6 backup without abe", {7'd0, irq_n}, 8'h01);
        wr(3'd4, 8'h03);
        check("R6 backup with abe", {7'd0, irq_n}, 8'h00);
        on_backup = 1'b0;
        #1;
        check("R6 main with both", {7'd0, irq_n}, 8'h00);
        flag_clear();

        // R7 power-up with coincident match and write
        bus_sel = 3'd4; bus_wdata = 8'h03; bus_wr = 1'b1; pwr_up = 1'b1;
        tick_at(8'h11, 8'h11, 8'h11, 8'h11);
        bus_wr = 1'b0; pwr_up = 1'b0;
        rd_check("R7 enables cleared", 3'd4, 8'h00);
        check("R7 flag still set", {7'd0, alarm_flag}, 8'h01);
        check("R7 line quiet", {7'd0, irq_n}, 8'h01);
        flag_clear();

        // R8 tone selection
        osc_run = 1'b1; ft_en = 1'b1; wd_steer = 1'b1; wd_cfg = 8'h33; tone512 = 1'b0;
        #1; check("R8 tone low steer", {7'd0, irq_n}, 8'h00);
        tone512 = 1'b1;
        #1; check("R8 tone high steer", {7'd0, irq_n}, 8'h01);
        wd_steer = 1'b0; wd_cfg = 8'h00; tone512 = 1'b0;
        #1; check("R8 tone wd zero", {7'd0, irq_n}, 8'h00);
        wd_cfg = 8'h05;
        #1; check("R8 no tone wd set", {7'd0, irq_n}, 8'h01);
        wd_cfg = 8'h00; osc_run = 1'b0;
        #1; check("R8 no tone osc off", {7'd0, irq_n}, 8'h01);
        osc_run = 1'b1; ft_en = 1'b0;
        #1; check("R8 no tone ft off", {7'd0, irq_n}, 8'h01);
        ft_en = 1'b1;
        wr(3'd4, 8'h01);
        check("R8 no tone with ae", {7'd0, irq_n}, 8'h01);
        wr(3'd4, 8'h00);

        // R9 watchdog prevails over tone
        tone512 = 1'b1;
        #1; check("R9 tone high before", {7'd0, irq_n}, 8'h01);
        wd_irq = 1'b1;
        #1; check("R9 watchdog wins", {7'd0, irq_n}, 8'h00);
        cyc();
        wd_irq = 1'b0; ft_en = 1'b0;
        cyc();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule